// File: doc/BRIEF.md
# Bus Master Retry and Ready-Wait Watchdog

This block sits beside the master side of a PCI-style parallel bus and decides when the master has to give up on the transaction it is running. It has two watchdogs. The first counts retry terminations returned by the target during one transaction. The second counts bus clocks in which the target holds device-select but shows neither target-ready nor stop. Either watchdog can end the transaction. When one does, the block emits a one-cycle abort pulse and sets a sticky status flag that records which watchdog fired.

Both limits share one small control word, written through byte lanes. A zero in either limit field switches that watchdog off. Each limit is captured when a transaction starts, so a write made while a transaction is running applies only from the next transaction. A separate status word holds the two sticky flags. Software clears a flag by writing a one to it.

Top module: `tmo_monitor`

## Requirements
- R1: After reset, both limit fields hold 0x80, so the control word reads 0x00008080. Both sticky flags read zero and the abort output is low.
- R2: In the control word (reg_sel=0), the retry limit sits in bits 15:8 and the ready-wait limit in bits 7:0. Bits 31:16 always read zero.
- R3: Byte lane k of the control word (bits 8k+7:8k) changes on a write only when reg_be[k] is set. A disabled lane keeps its value.
- R4: With a retry limit L from 1 to 255, the master accepts L retries in one transaction. The retry number L+1 is sampled at a clock edge, and the abort pulse is high after that same edge.
- R5: A retry limit of zero accepts any number of retries without an abort.
- R6: The retry count returns to zero when a transaction starts, including a restart during an active transaction, and when a transaction completes through txn_done.
- R7: A waiting cycle is an active-transaction edge with devsel_s=1, trdy_s=0 and stop_s=0. With a ready-wait limit N from 1 to 255, the abort pulse is high after the edge that samples the Nth consecutive waiting cycle.
- R8: A non-waiting edge inside the transaction restarts the ready-wait count from zero. This covers trdy_s high, stop_s high, or devsel_s low.
- R9: A ready-wait limit of zero lets the master wait for any number of cycles without an abort.
- R10: The abort output is high for exactly one cycle, and it ends the transaction. Retries and waiting cycles after an abort have no effect until the next txn_start.
- R11: The status word (reg_sel=1) shows the retry-abort flag in bit 0 and the ready-wait-abort flag in bit 1. Each flag stays set until a write with reg_be[0]=1 carries a one in that bit. A write with reg_be[0]=0 leaves both flags unchanged.
- R12: A write to a limit field shows in the control word at once. The watchdogs use the limit value as it stood at the edge of txn_start, until the next txn_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| txn_start | input | 1 | Pulse: a master transaction begins (restarts if one is active) |
| txn_done | input | 1 | Pulse: the transaction completed successfully |
| devsel_s | input | 1 | Sampled device-select from the target, active high |
| trdy_s | input | 1 | Sampled target-ready, active high |
| stop_s | input | 1 | Sampled stop, active high |
| retry_s | input | 1 | One retry termination seen on this edge |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 the status word |
| reg_be | input | 2 | Byte enables for the implemented lanes |
| reg_wdata | input | 16 | Write data for the implemented lanes |
| reg_rdata | output | 32 | Read data of the selected word |
| mst_abort | output | 1 | One-cycle master-abort pulse |
| retry_abort_flag | output | 1 | Sticky: the retry watchdog fired |
| wait_abort_flag | output | 1 | Sticky: the ready-wait watchdog fired |

## Verification
The bench builds the block with its default parameters: 8-bit limit fields, a 32-bit read word and both reset limits at 0x80. Because the bench writes limits at run time, it can use small values such as 1, 2, 3 and 5 to reach both abort thresholds within a few cycles. It also reaches the top boundary of 255 retries and runs 300-cycle stretches with each watchdog switched off. A single build therefore covers the low edge, the high edge and the disabled case of both fields.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  typedef enum logic {
    SEL_LIMITS = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;

  localparam int unsigned ST_RETRY = 0;
  localparam int unsigned ST_WAIT  = 1;
endpackage

// File: rtl/tmo_ctrl_reg.sv
module tmo_ctrl_reg
  import tmo_pkg::*;
#(
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [LIM_W-1:0] RETRY_RST = 8'h80,
  parameter logic [LIM_W-1:0] WAIT_RST  = 8'h80
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic                    sel,
  input  logic [2*LIM_W/8-1:0]    be,
  input  logic [2*LIM_W-1:0]      wdata,
  input  logic                    set_retry,
  input  logic                    set_wait,
  output logic [LIM_W-1:0]        retry_lim,
  output logic [LIM_W-1:0]        wait_lim,
  output logic                    sts_retry,
  output logic                    sts_wait,
  output logic [DATA_W-1:0]       rdata
);
  localparam int unsigned WORD_W = 2 * LIM_W;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam logic [WORD_W-1:0] WORD_RST = {RETRY_RST, WAIT_RST};

  logic [LANES-1:0][7:0] lane_q;
  logic [WORD_W-1:0]     word;
  logic                  wr_limits;
  logic                  wr_status;

  assign wr_limits = wr && (reg_sel_e'(sel) == SEL_LIMITS);
  assign wr_status = wr && (reg_sel_e'(sel) == SEL_STATUS) && be[0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        lane_q[g] <= WORD_RST[8*g +: 8];
      else if (wr_limits && be[g])
        lane_q[g] <= wdata[8*g +: 8];
    end
    assign word[8*g +: 8] = lane_q[g];
  end

  assign retry_lim = word[WORD_W-1:LIM_W];
  assign wait_lim  = word[LIM_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_retry <= 1'b0;
      sts_wait  <= 1'b0;
    end else begin
      if (set_retry)                           sts_retry <= 1'b1;
      else if (wr_status && wdata[ST_RETRY])   sts_retry <= 1'b0;
      if (set_wait)                            sts_wait  <= 1'b1;
      else if (wr_status && wdata[ST_WAIT])    sts_wait  <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (reg_sel_e'(sel) == SEL_STATUS) begin
      rdata[ST_RETRY] = sts_retry;
      rdata[ST_WAIT]  = sts_wait;
    end else begin
      rdata[WORD_W-1:0] = word;
    end
  end
endmodule

// File: rtl/tmo_retry_wd.sv
module tmo_retry_wd #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  input  logic [LIM_W-1:0] lim,
  output logic             fire,
  output logic [LIM_W-1:0] cnt
);
  localparam logic [LIM_W-1:0] ONE  = {{(LIM_W-1){1'b0}}, 1'b1};
  localparam logic [LIM_W-1:0] FULL = {LIM_W{1'b1}};

  function automatic logic [LIM_W-1:0] sat_inc(input logic [LIM_W-1:0] v);
    return (v == FULL) ? v : v + ONE;
  endfunction

  function automatic logic over_limit(input logic [LIM_W-1:0] c,
                                      input logic [LIM_W-1:0] l);
    return (l != '0) && (c >= l);
  endfunction

  assign fire = hit && over_limit(cnt, lim);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || fire) cnt <= '0;
    else if (hit)        cnt <= sat_inc(cnt);
  end
endmodule

// File: rtl/tmo_wait_wd.sv
module tmo_wait_wd #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             waiting,
  input  logic [LIM_W-1:0] lim,
  output logic             fire,
  output logic [LIM_W-1:0] cnt
);
  localparam logic [LIM_W-1:0] ONE  = {{(LIM_W-1){1'b0}}, 1'b1};
  localparam logic [LIM_W-1:0] FULL = {LIM_W{1'b1}};
  localparam logic [LIM_W:0]   ONE_X = {{LIM_W{1'b0}}, 1'b1};

  function automatic logic [LIM_W-1:0] sat_inc(input logic [LIM_W-1:0] v);
    return (v == FULL) ? v : v + ONE;
  endfunction

  function automatic logic expired(input logic [LIM_W-1:0] c,
                                   input logic [LIM_W-1:0] l);
    return (l != '0) && (({1'b0, c} + ONE_X) >= {1'b0, l});
  endfunction

  assign fire = waiting && expired(cnt, lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr || fire || !waiting) cnt <= '0;
    else                            cnt <= sat_inc(cnt);
  end
endmodule

// File: rtl/tmo_monitor.sv
module tmo_monitor #(
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [LIM_W-1:0] RETRY_RST = 8'h80,
  parameter logic [LIM_W-1:0] WAIT_RST  = 8'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 txn_start,
  input  logic                 txn_done,
  input  logic                 devsel_s,
  input  logic                 trdy_s,
  input  logic                 stop_s,
  input  logic                 retry_s,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [2*LIM_W/8-1:0] reg_be,
  input  logic [2*LIM_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 mst_abort,
  output logic                 retry_abort_flag,
  output logic                 wait_abort_flag
);
  logic             active_q;
  logic [LIM_W-1:0] retry_lim, wait_lim;
  logic [LIM_W-1:0] eff_retry, eff_wait;
  logic [LIM_W-1:0] retry_cnt, wait_cnt;
  logic             retry_hit, waiting;
  logic             retry_fire, wait_fire, any_fire;
  logic             wd_clr;

  assign retry_hit = active_q && retry_s;
  assign waiting   = active_q && devsel_s && !trdy_s && !stop_s;
  assign any_fire  = retry_fire || wait_fire;
  assign wd_clr    = txn_start || txn_done || any_fire;

  tmo_ctrl_reg #(
    .LIM_W(LIM_W), .DATA_W(DATA_W), .RETRY_RST(RETRY_RST), .WAIT_RST(WAIT_RST)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .be(reg_be),
    .wdata(reg_wdata), .set_retry(retry_fire), .set_wait(wait_fire),
    .retry_lim(retry_lim), .wait_lim(wait_lim),
    .sts_retry(retry_abort_flag), .sts_wait(wait_abort_flag), .rdata(reg_rdata)
  );

  tmo_retry_wd #(.LIM_W(LIM_W)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr(wd_clr), .hit(retry_hit),
    .lim(eff_retry), .fire(retry_fire), .cnt(retry_cnt)
  );

  tmo_wait_wd #(.LIM_W(LIM_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr(wd_clr), .waiting(waiting),
    .lim(eff_wait), .fire(wait_fire), .cnt(wait_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      eff_retry <= RETRY_RST;
      eff_wait  <= WAIT_RST;
      mst_abort <= 1'b0;
    end else begin
      mst_abort <= any_fire;
      if (txn_start) begin
        active_q  <= 1'b1;
        eff_retry <= retry_lim;
        eff_wait  <= wait_lim;
      end else if (txn_done || any_fire) begin
        active_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmo_monitor_chk.sv
module tmo_monitor_chk #(
  parameter int unsigned LIM_W = 8,
  parameter int unsigned RSV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_start,
  input logic             limits_view,
  input logic [RSV_W-1:0] rsv_bits,
  input logic             clr_retry,
  input logic             clr_wait,
  input logic             active_q,
  input logic [LIM_W-1:0] eff_retry,
  input logic [LIM_W-1:0] eff_wait,
  input logic             retry_fire,
  input logic             wait_fire,
  input logic             mst_abort,
  input logic             retry_abort_flag,
  input logic             wait_abort_flag
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    limits_view |-> (rsv_bits == '0));

  p_retry_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_retry == '0) |-> !retry_fire);

  p_wait_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_wait == '0) |-> !wait_fire);

  p_fire_aborts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_fire || wait_fire) |=> mst_abort);

  p_abort_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_abort && !$past(txn_start)) |=> !mst_abort);

  p_retry_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_abort_flag && !clr_retry) |=> retry_abort_flag);

  p_wait_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_abort_flag && !clr_wait) |=> wait_abort_flag);

  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    retry_fire |=> retry_abort_flag);

  p_limits_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !txn_start) |=> ($stable(eff_retry) && $stable(eff_wait)));
endmodule

bind tmo_monitor tmo_monitor_chk #(.LIM_W(LIM_W), .RSV_W(DATA_W - 2*LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_start(txn_start),
  .limits_view(reg_sel == 1'b0),
  .rsv_bits(reg_rdata[DATA_W-1:2*LIM_W]),
  .clr_retry(reg_wr && reg_sel && reg_be[0] && reg_wdata[0]),
  .clr_wait(reg_wr && reg_sel && reg_be[0] && reg_wdata[1]),
  .active_q(active_q), .eff_retry(eff_retry), .eff_wait(eff_wait),
  .retry_fire(retry_fire), .wait_fire(wait_fire), .mst_abort(mst_abort),
  .retry_abort_flag(retry_abort_flag), .wait_abort_flag(wait_abort_flag)
);

// File: tb/sim_tmo_monitor.sv
module sim_tmo_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_start = 1'b0, txn_done = 1'b0;
  logic        devsel_s = 1'b0, trdy_s = 1'b0, stop_s = 1'b0, retry_s = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [1:0]  reg_be = 2'b00;
  logic [15:0] reg_wdata = 16'h0;
  logic [31:0] reg_rdata;
  logic        mst_abort, retry_abort_flag, wait_abort_flag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tmo_monitor u0 (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_done(txn_done),
    .devsel_s(devsel_s), .trdy_s(trdy_s), .stop_s(stop_s), .retry_s(retry_s),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mst_abort(mst_abort),
    .retry_abort_flag(retry_abort_flag), .wait_abort_flag(wait_abort_flag)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [1:0] be, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_be = be; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_be = 2'b00; reg_wdata = 16'h0; reg_sel = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [31:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic start_txn;
    txn_start = 1'b1; tick(); txn_start = 1'b0;
  endtask

  task automatic done_txn;
    txn_done = 1'b1; tick(); txn_done = 1'b0;
  endtask

  task automatic one_retry;
    retry_s = 1'b1; tick(); retry_s = 1'b0;
  endtask

  task automatic bus_cycle(input logic dv, input logic tr, input logic st);
    devsel_s = dv; trdy_s = tr; stop_s = st;
    tick();
    devsel_s = 1'b0; trdy_s = 1'b0; stop_s = 1'b0;
  endtask

  task automatic clear_flags;
    reg_write(1'b1, 2'b01, 16'h0003);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    reg_read(1'b0, v); chk(v, 32'h0000_8080, "R1 control word after reset");
    reg_read(1'b1, v); chk(v, 32'h0, "R1 status after reset");
    chk(mst_abort, 1'b0, "R1 abort low after reset");
  endtask

  task automatic t_layout;
    logic [31:0] v;
    reg_write(1'b0, 2'b11, 16'h1234);
    reg_read(1'b0, v); chk(v, 32'h0000_1234, "R2 fields and reserved bits");
    reg_write(1'b0, 2'b10, 16'hAB00);
    reg_read(1'b0, v); chk(v, 32'h0000_AB34, "R3 upper lane only");
    reg_write(1'b0, 2'b01, 16'hFF56);
    reg_read(1'b0, v); chk(v, 32'h0000_AB56, "R3 lower lane only");
    reg_write(1'b0, 2'b00, 16'h0000);
    reg_read(1'b0, v); chk(v, 32'h0000_AB56, "R3 no lane enabled");
  endtask

  task automatic t_retry_limit;
    logic [31:0] v;
    int n;
    reg_write(1'b0, 2'b11, 16'h0300);
    start_txn();
    n = 0;
    for (int i = 0; i < 3; i++) begin one_retry(); n += int'(mst_abort); end
    chk(n, 0, "R4 three retries accepted");
    one_retry();
    chk(mst_abort, 1'b1, "R4 fourth retry aborts");
    chk(retry_abort_flag, 1'b1, "R11 retry flag set");
    tick();
    chk(mst_abort, 1'b0, "R10 abort lasts one cycle");
    one_retry();
    chk(mst_abort, 1'b0, "R10 no abort after transaction ended");
    reg_read(1'b1, v); chk(v, 32'h1, "R11 status shows retry bit");
    reg_write(1'b1, 2'b10, 16'h0003);
    reg_read(1'b1, v); chk(v, 32'h1, "R11 write without lane 0 keeps flag");
    reg_write(1'b1, 2'b01, 16'h0001);
    reg_read(1'b1, v); chk(v, 32'h0, "R11 write one clears flag");
    reg_write(1'b0, 2'b11, 16'hFF00);
    start_txn();
    n = 0;
    for (int i = 0; i < 255; i++) begin one_retry(); n += int'(mst_abort); end
    chk(n, 0, "R4 limit 255 accepts 255 retries");
    one_retry();
    chk(mst_abort, 1'b1, "R4 retry 256 aborts at limit 255");
    clear_flags();
  endtask

  task automatic t_retry_off;
    int n;
    reg_write(1'b0, 2'b11, 16'h0000);
    start_txn();
    n = 0;
    for (int i = 0; i < 300; i++) begin one_retry(); n += int'(mst_abort); end
    chk(n, 0, "R5 unlimited retries");
    chk(retry_abort_flag, 1'b0, "R5 no retry flag");
    done_txn();
  endtask

  task automatic t_retry_clear;
    int n;
    reg_write(1'b0, 2'b11, 16'h0200);
    start_txn();
    one_retry(); one_retry();
    done_txn();
    start_txn();
    n = 0;
    one_retry(); n += int'(mst_abort);
    one_retry(); n += int'(mst_abort);
    chk(n, 0, "R6 count cleared by completion");
    one_retry();
    chk(mst_abort, 1'b1, "R6 third retry in new transaction aborts");
    start_txn();
    one_retry(); one_retry();
    start_txn();
    n = 0;
    one_retry(); n += int'(mst_abort);
    one_retry(); n += int'(mst_abort);
    chk(n, 0, "R6 count cleared by restart");
    one_retry();
    chk(mst_abort, 1'b1, "R6 abort after restart count");
    clear_flags();
  endtask

  task automatic t_wait_limit;
    logic [31:0] v;
    int n;
    reg_write(1'b0, 2'b11, 16'h0005);
    start_txn();
    n = 0;
    for (int i = 0; i < 4; i++) begin bus_cycle(1'b1, 1'b0, 1'b0); n += int'(mst_abort); end
    chk(n, 0, "R7 four waiting cycles tolerated");
    bus_cycle(1'b1, 1'b0, 1'b0);
    chk(mst_abort, 1'b1, "R7 fifth waiting cycle aborts");
    reg_read(1'b1, v); chk(v, 32'h2, "R11 status shows wait bit");
    tick();
    chk(mst_abort, 1'b0, "R10 wait abort lasts one cycle");
    clear_flags();
    reg_write(1'b0, 2'b01, 16'h0001);
    start_txn();
    bus_cycle(1'b1, 1'b0, 1'b0);
    chk(mst_abort, 1'b1, "R7 limit 1 aborts on first waiting cycle");
    clear_flags();
  endtask

  task automatic t_wait_clear;
    int n;
    reg_write(1'b0, 2'b11, 16'h0005);
    start_txn();
    n = 0;
    for (int i = 0; i < 4; i++) begin bus_cycle(1'b1, 1'b0, 1'b0); n += int'(mst_abort); end
    bus_cycle(1'b1, 1'b1, 1'b0); n += int'(mst_abort);
    for (int i = 0; i < 4; i++) begin bus_cycle(1'b1, 1'b0, 1'b0); n += int'(mst_abort); end
    bus_cycle(1'b1, 1'b0, 1'b1); n += int'(mst_abort);
    for (int i = 0; i < 4; i++) begin bus_cycle(1'b1, 1'b0, 1'b0); n += int'(mst_abort); end
    bus_cycle(1'b0, 1'b0, 1'b0); n += int'(mst_abort);
    for (int i = 0; i < 4; i++) begin bus_cycle(1'b1, 1'b0, 1'b0); n += int'(mst_abort); end
    chk(n, 0, "R8 ready, stop and idle restart the wait count");
    bus_cycle(1'b1, 1'b0, 1'b0);
    chk(mst_abort, 1'b1, "R8 five uninterrupted waits abort");
    clear_flags();
  endtask

  task automatic t_wait_off;
    int n;
    reg_write(1'b0, 2'b11, 16'h0000);
    start_txn();
    n = 0;
    for (int i = 0; i < 300; i++) begin bus_cycle(1'b1, 1'b0, 1'b0); n += int'(mst_abort); end
    chk(n, 0, "R9 indefinite wait");
    chk(wait_abort_flag, 1'b0, "R9 no wait flag");
    done_txn();
  endtask

  task automatic t_mid_write;
    logic [31:0] v;
    int n;
    reg_write(1'b0, 2'b11, 16'h0005);
    start_txn();
    reg_write(1'b0, 2'b01, 16'h0002);
    reg_read(1'b0, v); chk(v, 32'h0000_0002, "R12 register updates at once");
    n = 0;
    for (int i = 0; i < 4; i++) begin bus_cycle(1'b1, 1'b0, 1'b0); n += int'(mst_abort); end
    chk(n, 0, "R12 old limit still in force");
    bus_cycle(1'b1, 1'b1, 1'b0);
    done_txn();
    start_txn();
    bus_cycle(1'b1, 1'b0, 1'b0);
    chk(mst_abort, 1'b0, "R12 new limit first wait");
    bus_cycle(1'b1, 1'b0, 1'b0);
    chk(mst_abort, 1'b1, "R12 new limit applies next transaction");
    clear_flags();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_layout();
    t_retry_limit();
    t_retry_off();
    t_retry_clear();
    t_wait_limit();
    t_wait_clear();
    t_wait_off();
    t_mid_write();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule